// File: doc/BRIEF.md
# Tamper Zeroization and Verify Sequencer

This block is the controller for a device's tamper response. It runs from a free-running internal oscillator clock, not the system clock. A stopped or tampered external clock therefore cannot stall a response once one is under way. Any of several tamper sources can start a wipe. Each source passes through a synchronizer and an enable mask. A wipe clears the configuration memory and then the embedded user memory. A separate command erases only the key register. When a key erase is requested while a wipe is running, it joins that wipe instead of waiting for a second run.

Verification can run on its own, or it can follow a wipe automatically. It requests a benign image load, waits for reconfiguration to finish, and then runs a CRC check over the configuration. The result is reported as pass or fail.

Every external agent is reached through a request/acknowledge pair. Each phase has a cycle limit. If a phase runs past that limit, the sequencer goes to a failure state and sets a sticky error flag. It then returns to idle.

Top module: `tamper_zero_seq`

## Requirements
- R1: After reset, busy, clear_done, verify_pass, verify_fail, err_timeout and all six request outputs are 0.
- R2: A tamper source starts a wipe only if its bit in tamper_mask is 1. A pulse on a source whose mask bit is 0 leaves busy at 0 and raises no request.
- R3: A wipe raises cram_clr_req until acknowledged, then eram_clr_req until acknowledged. At most one request output is high in any cycle.
- R4: Once a wipe has started, lowering the tamper source does not shorten it. busy stays high until the last phase is acknowledged.
- R5: A key_cmd pulse while idle runs only the key_clr_req handshake, then sets clear_done. Neither memory request is raised.
- R6: A key_cmd pulse during the memory phases of a wipe (or together with its trigger) adds exactly one key_clr_req handshake right after the embedded-memory clear. No second run follows.
- R7: Verification raises load_req, then recfg_req, then crc_req, each after the previous one is acknowledged. A wipe runs verification only if verify_en was 1 when it started.
- R8: A verify_cmd pulse while idle runs verification alone, with no clear requests, and leaves clear_done at 0.
- R9: When crc_ack arrives, verify_pass is set if crc_ok is 1, and verify_fail is set otherwise.
- R10: If a phase's acknowledge does not arrive within PHASE_LIMIT cycles, err_timeout is set and busy falls. The remaining phases are skipped and no result flag is set for the aborted phase. err_timeout stays 1 until reset.
- R11: clear_done, verify_pass and verify_fail hold their value while idle. They are cleared when the next run starts.
- R12: In idle, a tamper trigger has priority over key_cmd, and key_cmd has priority over verify_cmd. A verify_cmd that arrives in the same cycle as key_cmd is dropped.
- R13: key_cmd and verify_cmd have no effect while a verification is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Internal oscillator clock |
| osc_rst_n | input | 1 | Asynchronous active-low reset |
| tamper_src | input | N_SRC | Asynchronous tamper indications |
| tamper_mask | input | N_SRC | 1 enables the matching source |
| key_cmd | input | 1 | One-cycle request to erase only the key |
| verify_cmd | input | 1 | One-cycle request to run verification alone |
| verify_en | input | 1 | Run verification after a wipe |
| cram_clr_req | output | 1 | Configuration memory clear request |
| cram_clr_ack | input | 1 | Configuration memory clear done |
| eram_clr_req | output | 1 | Embedded memory clear request |
| eram_clr_ack | input | 1 | Embedded memory clear done |
| key_clr_req | output | 1 | Key register erase request |
| key_clr_ack | input | 1 | Key register erase done |
| load_req | output | 1 | Benign image load request |
| load_ack | input | 1 | Benign image loaded |
| recfg_req | output | 1 | Reconfiguration request |
| recfg_ack | input | 1 | Reconfiguration complete |
| crc_req | output | 1 | Configuration CRC check request |
| crc_ack | input | 1 | CRC check complete |
| crc_ok | input | 1 | CRC result, valid with crc_ack |
| busy | output | 1 | Sequencer not idle |
| clear_done | output | 1 | Clear phase completed |
| verify_pass | output | 1 | Verification passed |
| verify_fail | output | 1 | Verification failed |
| err_timeout | output | 1 | Sticky phase timeout flag |

## Verification
Two events can fall in the same cycle: a key_cmd and a wipe that is in flight, or a key_cmd and a verify_cmd while idle. For the first case, the bench pulses key_cmd on the first cycle busy is seen high. At that point the configuration memory handshake may be acknowledged in the same cycle. The bench logs the order of acknowledged handshakes and expects exactly one key erase, placed after the embedded memory clear. For the second case, the bench drives key_cmd and verify_cmd in the same cycle. It expects a lone key handshake, clear_done set, and both verify flags clear.

// File: rtl/tzs_pkg.sv
package tzs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CRAM  = 3'd1,
    ST_ERAM  = 3'd2,
    ST_KEY   = 3'd3,
    ST_LOAD  = 3'd4,
    ST_RECFG = 3'd5,
    ST_CRC   = 3'd6,
    ST_FAIL  = 3'd7
  } tzs_state_e;

  localparam int unsigned NUM_HS = 6;

endpackage

// File: rtl/tzs_trigger.sv
module tzs_trigger #(
  parameter int unsigned N_SRC       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src,
  input  logic [N_SRC-1:0] mask,
  output logic             hit
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [N_SRC-1:0] synced;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      logic [SYNC_STAGES-1:0] chain_d;

      if (SYNC_STAGES > 1) begin : g_multi
        assign chain_d = {chain_q[SYNC_STAGES-2:0], src[g]};
      end else begin : g_single
        assign chain_d = src[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end

      assign synced[g] = chain_q[LAST];
    end
  endgenerate

  // wide OR of every enabled source
  assign hit = |(synced & mask);

endmodule

// File: rtl/tzs_watchdog.sv
module tzs_watchdog #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expired
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = restart || run;
    if (restart)            cnt_d = '0;
    else if (cnt_q != LAST_CNT) cnt_d = cnt_q + 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == LAST_CNT);

endmodule

// File: rtl/tzs_fsm.sv
module tzs_fsm
  import tzs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       key_cmd,
  input  logic       verify_cmd,
  input  logic       verify_en,
  input  logic       cram_ack,
  input  logic       eram_ack,
  input  logic       key_ack,
  input  logic       load_ack,
  input  logic       recfg_ack,
  input  logic       crc_ack,
  input  logic       expired,
  output tzs_state_e state,
  output logic       in_phase,
  output logic       restart,
  output logic       start_evt,
  output logic       clr_evt,
  output logic       vfy_evt,
  output logic       to_evt
);

  tzs_state_e state_q, state_d;
  logic       key_pend_q, key_pend_d;
  logic       vfy_pend_q, vfy_pend_d;
  logic       ack_cur;

  always_comb begin
    case (state_q)
      ST_CRAM:  ack_cur = cram_ack;
      ST_ERAM:  ack_cur = eram_ack;
      ST_KEY:   ack_cur = key_ack;
      ST_LOAD:  ack_cur = load_ack;
      ST_RECFG: ack_cur = recfg_ack;
      ST_CRC:   ack_cur = crc_ack;
      default:  ack_cur = 1'b0;
    endcase
  end

  assign in_phase = (state_q != ST_IDLE) && (state_q != ST_FAIL);

  // next-state process
  always_comb begin
    state_d    = state_q;
    key_pend_d = key_pend_q;
    vfy_pend_d = vfy_pend_q;
    start_evt  = 1'b0;
    clr_evt    = 1'b0;
    vfy_evt    = 1'b0;
    to_evt     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (hit) begin
          state_d    = ST_CRAM;
          key_pend_d = key_cmd;
          vfy_pend_d = verify_en;
          start_evt  = 1'b1;
        end else if (key_cmd) begin
          state_d    = ST_KEY;
          key_pend_d = 1'b0;
          vfy_pend_d = 1'b0;
          start_evt  = 1'b1;
        end else if (verify_cmd) begin
          state_d    = ST_LOAD;
          key_pend_d = 1'b0;
          vfy_pend_d = 1'b1;
          start_evt  = 1'b1;
        end
      end
      ST_CRAM: begin
        if (key_cmd) key_pend_d = 1'b1;
        if (ack_cur)      state_d = ST_ERAM;
        else if (expired) state_d = ST_FAIL;
      end
      ST_ERAM: begin
        if (ack_cur) begin
          if (key_pend_q || key_cmd) begin
            state_d = ST_KEY;
          end else begin
            clr_evt = 1'b1;
            state_d = vfy_pend_q ? ST_LOAD : ST_IDLE;
          end
          key_pend_d = 1'b0;
        end else begin
          if (key_cmd) key_pend_d = 1'b1;
          if (expired) state_d = ST_FAIL;
        end
      end
      ST_KEY: begin
        if (ack_cur) begin
          clr_evt = 1'b1;
          state_d = vfy_pend_q ? ST_LOAD : ST_IDLE;
        end else if (expired) begin
          state_d = ST_FAIL;
        end
      end
      ST_LOAD: begin
        if (ack_cur)      state_d = ST_RECFG;
        else if (expired) state_d = ST_FAIL;
      end
      ST_RECFG: begin
        if (ack_cur)      state_d = ST_CRC;
        else if (expired) state_d = ST_FAIL;
      end
      ST_CRC: begin
        if (ack_cur) begin
          vfy_evt = 1'b1;
          state_d = ST_IDLE;
        end else if (expired) begin
          state_d = ST_FAIL;
        end
      end
      ST_FAIL: begin
        state_d    = ST_IDLE;
        key_pend_d = 1'b0;
        vfy_pend_d = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
    if (in_phase && !ack_cur && expired) to_evt = 1'b1;
  end

  assign restart = (state_d != state_q);
  assign state   = state_q;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      key_pend_q <= 1'b0;
      vfy_pend_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      key_pend_q <= key_pend_d;
      vfy_pend_q <= vfy_pend_d;
    end
  end

endmodule

// File: rtl/tzs_status.sv
module tzs_status (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic clr_evt,
  input  logic vfy_evt,
  input  logic vfy_ok,
  input  logic to_evt,
  output logic clear_done,
  output logic verify_pass,
  output logic verify_fail,
  output logic err_timeout
);

  logic cd_en, cd_d;
  logic vr_en, vp_d, vf_d;
  logic er_en;

  always_comb begin
    cd_en = start_evt || clr_evt;
    cd_d  = clr_evt;
    vr_en = start_evt || vfy_evt;
    vp_d  = vfy_evt && vfy_ok;
    vf_d  = vfy_evt && !vfy_ok;
    er_en = to_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clear_done  <= 1'b0;
      verify_pass <= 1'b0;
      verify_fail <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      if (cd_en) clear_done <= cd_d;
      if (vr_en) begin
        verify_pass <= vp_d;
        verify_fail <= vf_d;
      end
      if (er_en) err_timeout <= 1'b1;
    end
  end

endmodule

// File: rtl/tamper_zero_seq.sv
module tamper_zero_seq
  import tzs_pkg::*;
#(
  parameter int unsigned N_SRC       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PHASE_LIMIT = 64
) (
  input  logic             osc_clk,
  input  logic             osc_rst_n,
  input  logic [N_SRC-1:0] tamper_src,
  input  logic [N_SRC-1:0] tamper_mask,
  input  logic             key_cmd,
  input  logic             verify_cmd,
  input  logic             verify_en,
  output logic             cram_clr_req,
  input  logic             cram_clr_ack,
  output logic             eram_clr_req,
  input  logic             eram_clr_ack,
  output logic             key_clr_req,
  input  logic             key_clr_ack,
  output logic             load_req,
  input  logic             load_ack,
  output logic             recfg_req,
  input  logic             recfg_ack,
  output logic             crc_req,
  input  logic             crc_ack,
  input  logic             crc_ok,
  output logic             busy,
  output logic             clear_done,
  output logic             verify_pass,
  output logic             verify_fail,
  output logic             err_timeout
);

  // reset: asserted asynchronously, released on the oscillator clock
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) rst_sync_q <= 2'b00;
    else            rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic       hit;
  logic       expired;
  tzs_state_e state;
  logic       in_phase, restart;
  logic       start_evt, clr_evt, vfy_evt, to_evt;

  tzs_trigger #(
    .N_SRC       (N_SRC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_trig (
    .clk   (osc_clk),
    .rst_n (rst_n_i),
    .src   (tamper_src),
    .mask  (tamper_mask),
    .hit   (hit)
  );

  tzs_fsm u_fsm (
    .clk        (osc_clk),
    .rst_n      (rst_n_i),
    .hit        (hit),
    .key_cmd    (key_cmd),
    .verify_cmd (verify_cmd),
    .verify_en  (verify_en),
    .cram_ack   (cram_clr_ack),
    .eram_ack   (eram_clr_ack),
    .key_ack    (key_clr_ack),
    .load_ack   (load_ack),
    .recfg_ack  (recfg_ack),
    .crc_ack    (crc_ack),
    .expired    (expired),
    .state      (state),
    .in_phase   (in_phase),
    .restart    (restart),
    .start_evt  (start_evt),
    .clr_evt    (clr_evt),
    .vfy_evt    (vfy_evt),
    .to_evt     (to_evt)
  );

  tzs_watchdog #(
    .LIMIT (PHASE_LIMIT)
  ) u_wdog (
    .clk     (osc_clk),
    .rst_n   (rst_n_i),
    .run     (in_phase),
    .restart (restart),
    .expired (expired)
  );

  tzs_status u_stat (
    .clk         (osc_clk),
    .rst_n       (rst_n_i),
    .start_evt   (start_evt),
    .clr_evt     (clr_evt),
    .vfy_evt     (vfy_evt),
    .vfy_ok      (crc_ok),
    .to_evt      (to_evt),
    .clear_done  (clear_done),
    .verify_pass (verify_pass),
    .verify_fail (verify_fail),
    .err_timeout (err_timeout)
  );

  assign cram_clr_req = (state == ST_CRAM);
  assign eram_clr_req = (state == ST_ERAM);
  assign key_clr_req  = (state == ST_KEY);
  assign load_req     = (state == ST_LOAD);
  assign recfg_req    = (state == ST_RECFG);
  assign crc_req      = (state == ST_CRC);
  assign busy         = (state != ST_IDLE);

endmodule

// File: rtl/tzs_checker.sv
module tzs_checker (
  input logic osc_clk,
  input logic osc_rst_n,
  input logic cram_clr_req,
  input logic eram_clr_req,
  input logic key_clr_req,
  input logic load_req,
  input logic recfg_req,
  input logic crc_req,
  input logic busy,
  input logic clear_done,
  input logic verify_pass,
  input logic verify_fail,
  input logic err_timeout
);

  logic [5:0] reqs;
  assign reqs = {crc_req, recfg_req, load_req, key_clr_req, eram_clr_req, cram_clr_req};

  a_r3_one_request: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    $onehot0(reqs));

  a_r1_idle_no_request: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    !busy |-> (reqs == 6'b0));

  a_r3_eram_after_cram: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    $rose(eram_clr_req) |-> $past(cram_clr_req));

  a_r7_recfg_after_load: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    $rose(recfg_req) |-> $past(load_req));

  a_r7_crc_after_recfg: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    $rose(crc_req) |-> $past(recfg_req));

  a_r10_err_sticky: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    err_timeout |=> err_timeout);

  a_r9_pass_fail_excl: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    !(verify_pass && verify_fail));

  a_r11_flags_hold_idle: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    (!busy && !$past(busy)) |-> $stable({clear_done, verify_pass, verify_fail}));

endmodule

bind tamper_zero_seq tzs_checker u_chk (
  .osc_clk      (osc_clk),
  .osc_rst_n    (osc_rst_n),
  .cram_clr_req (cram_clr_req),
  .eram_clr_req (eram_clr_req),
  .key_clr_req  (key_clr_req),
  .load_req     (load_req),
  .recfg_req    (recfg_req),
  .crc_req      (crc_req),
  .busy         (busy),
  .clear_done   (clear_done),
  .verify_pass  (verify_pass),
  .verify_fail  (verify_fail),
  .err_timeout  (err_timeout)
);

// File: tb/tb_tamper_zero_seq.sv
module tb_tamper_zero_seq;

  localparam int CLK_PERIOD = 10;
  localparam int N_SRC      = 8;

  logic clk, rst_n;
  logic [N_SRC-1:0] tamper_src, tamper_mask;
  logic key_cmd, verify_cmd, verify_en, crc_ok;
  logic [6:1] ack_bits;
  logic [6:0] hang;
  logic cram_clr_req, eram_clr_req, key_clr_req, load_req, recfg_req, crc_req;
  logic busy, clear_done, verify_pass, verify_fail, err_timeout;

  int errors = 0;
  int checks = 0;
  int act_word;

  tamper_zero_seq #(.N_SRC(N_SRC), .SYNC_STAGES(2), .PHASE_LIMIT(64)) dut (
    .osc_clk(clk), .osc_rst_n(rst_n),
    .tamper_src(tamper_src), .tamper_mask(tamper_mask),
    .key_cmd(key_cmd), .verify_cmd(verify_cmd), .verify_en(verify_en),
    .cram_clr_req(cram_clr_req), .cram_clr_ack(ack_bits[1]),
    .eram_clr_req(eram_clr_req), .eram_clr_ack(ack_bits[2]),
    .key_clr_req(key_clr_req),   .key_clr_ack(ack_bits[3]),
    .load_req(load_req),         .load_ack(ack_bits[4]),
    .recfg_req(recfg_req),       .recfg_ack(ack_bits[5]),
    .crc_req(crc_req),           .crc_ack(ack_bits[6]),
    .crc_ok(crc_ok),
    .busy(busy), .clear_done(clear_done), .verify_pass(verify_pass),
    .verify_fail(verify_fail), .err_timeout(err_timeout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // handshake codes: 1 cram, 2 eram, 3 key, 4 load, 5 recfg, 6 crc
  function automatic logic req_of(int code);
    case (code)
      1: return cram_clr_req;
      2: return eram_clr_req;
      3: return key_clr_req;
      4: return load_req;
      5: return recfg_req;
      default: return crc_req;
    endcase
  endfunction

  // expected order of acknowledged handshakes, one hex digit per phase
  function automatic int exp_word(bit wipe, bit key, bit vfy);
    int w = 0;
    if (wipe) w = (w << 8) | 32'h12;
    if (key)  w = (w << 4) | 32'h3;
    if (vfy)  w = (w << 12) | 32'h456;
    return w;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic responder(int code);
    forever begin
      @(negedge clk);
      if (rst_n && req_of(code) && !hang[code]) begin
        int d;
        d = $urandom_range(0, 3);
        repeat (d) @(negedge clk);
        ack_bits[code] = 1'b1;
        act_word = (act_word << 4) | code;
        @(negedge clk);
        ack_bits[code] = 1'b0;
      end
    end
  endtask

  initial responder(1);
  initial responder(2);
  initial responder(3);
  initial responder(4);
  initial responder(5);
  initial responder(6);

  task automatic wait_rise(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 10 && !ok; i++) begin
      @(negedge clk);
      if (busy) ok = 1'b1;
    end
  endtask

  task automatic wait_fall(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      @(negedge clk);
      if (!busy) ok = 1'b1;
    end
  endtask

  task automatic check_status(string req, bit cd, bit vp, bit vf);
    chk({req, " clear_done"}, int'(clear_done), int'(cd));
    chk({req, " verify_pass"}, int'(verify_pass), int'(vp));
    chk({req, " verify_fail"}, int'(verify_fail), int'(vf));
  endtask

  // tamper-triggered wipe; source dropped as soon as busy is seen (R4)
  task automatic run_tamper(int src, bit ven, bit key_mid, bit good);
    bit ok;
    act_word  = 0;
    verify_en = ven;
    crc_ok    = good;
    @(negedge clk);
    tamper_src[src] = 1'b1;
    wait_rise(ok);
    tamper_src[src] = 1'b0;
    chk("R2 unmasked source starts wipe", int'(ok), 1);
    if (key_mid) begin
      key_cmd = 1'b1;
      @(negedge clk);
      key_cmd = 1'b0;
    end
    wait_fall(ok);
    chk("R4 wipe completes after trigger release", int'(ok), 1);
    chk("R3 R6 R7 handshake order", act_word, exp_word(1'b1, key_mid, ven));
    check_status("R9 R11 after wipe", 1'b1, ven && good, ven && !good);
  endtask

  task automatic pulse_cmd(bit k, bit v);
    @(negedge clk);
    key_cmd    = k;
    verify_cmd = v;
    @(negedge clk);
    key_cmd    = 1'b0;
    verify_cmd = 1'b0;
  endtask

  initial begin
    bit ok;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    tamper_src = '0; tamper_mask = '1;
    key_cmd = 1'b0; verify_cmd = 1'b0; verify_en = 1'b0; crc_ok = 1'b1;
    ack_bits = '0; hang = '0; act_word = 0;
    repeat (4) @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset requests", int'({cram_clr_req, eram_clr_req, key_clr_req, load_req, recfg_req, crc_req}), 0);
    check_status("R1 reset", 1'b0, 1'b0, 1'b0);
    chk("R1 reset err_timeout", int'(err_timeout), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: masked source is ignored
    tamper_mask = 8'hFE;
    act_word = 0;
    tamper_src[0] = 1'b1;
    repeat (4) @(negedge clk);
    tamper_src[0] = 1'b0;
    repeat (8) @(negedge clk);
    chk("R2 masked source busy", int'(busy), 0);
    chk("R2 masked source requests", act_word, 0);
    tamper_mask = '1;

    // directed wipes
    run_tamper(3, 1'b0, 1'b0, 1'b1);
    run_tamper(7, 1'b1, 1'b1, 1'b0);

    // R5: key-only erase
    act_word = 0;
    pulse_cmd(1'b1, 1'b0);
    wait_fall(ok);
    chk("R5 key-only order", act_word, exp_word(1'b0, 1'b1, 1'b0));
    check_status("R5 key-only", 1'b1, 1'b0, 1'b0);

    // R8: verify alone, failing CRC
    act_word = 0; crc_ok = 1'b0;
    pulse_cmd(1'b0, 1'b1);
    wait_fall(ok);
    chk("R8 verify-only order", act_word, exp_word(1'b0, 1'b0, 1'b1));
    check_status("R8 R9 verify-only", 1'b0, 1'b0, 1'b1);

    // R12: key and verify in the same idle cycle -> key only
    act_word = 0;
    pulse_cmd(1'b1, 1'b1);
    wait_fall(ok);
    chk("R12 key over verify order", act_word, exp_word(1'b0, 1'b1, 1'b0));
    check_status("R12 R11 key over verify", 1'b1, 1'b0, 1'b0);

    // R13: commands during verification are ignored
    act_word = 0; crc_ok = 1'b1;
    pulse_cmd(1'b0, 1'b1);
    for (int i = 0; i < 10 && !load_req; i++) @(negedge clk);
    key_cmd = 1'b1; verify_cmd = 1'b1;
    @(negedge clk);
    key_cmd = 1'b0; verify_cmd = 1'b0;
    wait_fall(ok);
    repeat (3) @(negedge clk);
    chk("R13 commands during verify order", act_word, exp_word(1'b0, 1'b0, 1'b1));
    chk("R13 idle after verify", int'(busy), 0);
    check_status("R13 status", 1'b0, 1'b1, 1'b0);

    // R10: hang embedded clear
    hang[2] = 1'b1;
    act_word = 0;
    @(negedge clk);
    tamper_src[1] = 1'b1;
    wait_rise(ok);
    tamper_src[1] = 1'b0;
    wait_fall(ok);
    chk("R10 timeout returns idle", int'(ok), 1);
    chk("R10 timeout stops sequence", act_word, 32'h1);
    chk("R10 err_timeout set", int'(err_timeout), 1);
    chk("R10 no clear_done on timeout", int'(clear_done), 0);
    hang[2] = 1'b0;

    // R10: hang crc during verify
    hang[6] = 1'b1;
    act_word = 0;
    pulse_cmd(1'b0, 1'b1);
    wait_fall(ok);
    chk("R10 crc timeout order", act_word, 32'h45);
    check_status("R10 crc timeout flags", 1'b0, 1'b0, 1'b0);
    hang[6] = 1'b0;

    // random mix
    for (int n = 0; n < 24; n++) begin
      int kind;
      kind = $urandom_range(0, 2);
      if (kind == 0) begin
        run_tamper($urandom_range(0, N_SRC-1), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end else if (kind == 1) begin
        act_word = 0;
        pulse_cmd(1'b1, 1'b0);
        wait_fall(ok);
        chk("R5 random key-only", act_word, exp_word(1'b0, 1'b1, 1'b0));
        check_status("R5 random key-only", 1'b1, 1'b0, 1'b0);
      end else begin
        bit good;
        good = 1'($urandom_range(0, 1));
        act_word = 0; crc_ok = good;
        pulse_cmd(1'b0, 1'b1);
        wait_fall(ok);
        chk("R8 random verify", act_word, exp_word(1'b0, 1'b0, 1'b1));
        check_status("R9 random verify", 1'b0, good, !good);
      end
    end

    chk("R10 err_timeout still sticky", int'(err_timeout), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule